// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block guards a peripheral's register file against stray writes. Software opens the gate by writing two fixed 32-bit key words, each to its own key register. While both key registers hold their exact key, writes may reach the protected registers. The gate locks again as soon as either key register receives any other value, so writing zero to the key registers is the normal way to close it. Reads are never blocked.

The block holds a small bank of general-purpose scratch words, and those words are protected as well. Every write to an address that the block does not own is forwarded as a write enable to the peripheral. That enable is raised only while the gate is open. The bus is a plain address, data, write-strobe and read-strobe interface. Read data comes back one cycle after the read strobe.

Top module: `keylock_regfile`

## Requirements
- R1: After a synchronous active-low reset the gate is locked (`unlocked` low) and every scratch word reads as zero.
- R2: `unlocked` goes high in the cycle after the write that leaves key register A (byte address 0x6C) holding 0x83E70B13 and key register B (byte address 0x70) holding 0x95A4F1E0. The two keys may be written in either order, and one correct key alone never opens the gate.
- R3: A write of any value other than its key to either key register, zero included, clears `unlocked` in the next cycle.
- R4: While the gate is locked, a write to a scratch word has no effect on its contents.
- R5: While the gate is open, a write to a scratch word (byte addresses 0x60, 0x64 and 0x68 for words 0 to 2) stores the data, and a read issued in the next cycle returns it.
- R6: Reads of either key register return zero whatever was written to it.
- R7: `periph_we` is high in the same cycle as `bus_wr` only when the gate is open and the address is neither a scratch word nor a key register. A write to a local address never raises it.
- R8: The scratch window ends below 0x6C. A word-aligned write at 0x74 or above, or any write whose address bits [1:0] are not zero, is treated as a peripheral write and leaves the scratch words unchanged.
- R9: `bus_rvalid` is high exactly in the cycle after `bus_rd`, and `bus_rdata` then carries the read result. A read of any address that is not a scratch word returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read result valid, one cycle after bus_rd |
| periph_we | output | 1 | Gated write enable toward the protected peripheral registers |
| unlocked | output | 1 | Gate open |

## Verification
`periph_we` is combinational and is sampled 1 ns after the inputs change, within the same cycle as the write. Key and scratch writes take effect at the next rising edge. For that reason, `unlocked` is compared at the start of the following bus operation, and reads that follow a write see its result. Each read pushes its expected word into a queue when it is issued. A monitor pops and compares that word 2 ns after the rising edge that registers `bus_rvalid`, exactly one cycle later. The monitor also flags any valid with no read outstanding.

// File: rtl/keylock_pkg.sv
// Shared types for the two-key write lock.
// Assumes byte addressing with 32-bit word registers.
package keylock_pkg;

    // Which local resource an address selects.
    typedef enum logic [1:0] {
        HIT_NONE    = 2'd0,
        HIT_SCRATCH = 2'd1,
        HIT_KEY_A   = 2'd2,
        HIT_KEY_B   = 2'd3
    } hit_e;

endpackage

// File: rtl/keylock_decode.sv
// Address decoder: classifies a byte address as a key register, a scratch
// word (with its index) or a non-local (peripheral) address.
// Assumes: only word-aligned addresses match locally; key registers win over
// the scratch window if the two ever overlap.
module keylock_decode
    import keylock_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                NUM_SCRATCH  = 3,
    parameter logic [ADDR_W-1:0] SCRATCH_BASE = 8'h60,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR   = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR   = 8'h70,
    localparam int               IDX_W        = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1,
    localparam int               WORD_W       = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output hit_e              hit_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [WORD_W-1:0] BASE_WORD = SCRATCH_BASE[ADDR_W-1:2];

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign word    = addr_i[ADDR_W-1:2];

    // Purpose: pick the local target; key registers take priority.
    always_comb begin
        hit_o = HIT_NONE;
        idx_o = '0;
        if (aligned) begin
            if (addr_i == KEY_A_ADDR) begin
                hit_o = HIT_KEY_A;
            end else if (addr_i == KEY_B_ADDR) begin
                hit_o = HIT_KEY_B;
            end else begin
                for (int i = 0; i < NUM_SCRATCH; i++) begin
                    if (word == BASE_WORD + WORD_W'(i)) begin
                        hit_o = HIT_SCRATCH;
                        idx_o = IDX_W'(i);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/keylock_keys.sv
// Key registers and lock state. Each key register keeps a single flag that
// records whether its last write matched its key; the gate is open while
// both flags are set. Assumes key writes arrive already decoded.
module keylock_keys #(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_A = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_B = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_a_wr_i,
    input  logic              key_b_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              unlocked_o
);

    logic a_ok;
    logic b_ok;

    // Purpose: record whether the latest write to key A matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ok <= 1'b0;
        end else if (key_a_wr_i) begin
            a_ok <= (wdata_i == KEY_A);
        end
    end

    // Purpose: record whether the latest write to key B matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_ok <= 1'b0;
        end else if (key_b_wr_i) begin
            b_ok <= (wdata_i == KEY_B);
        end
    end

    assign unlocked_o = a_ok & b_ok;

    // R3: a wrong value on either key closes the gate next cycle.
    p_bad_key_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((key_a_wr_i && wdata_i != KEY_A) || (key_b_wr_i && wdata_i != KEY_B))
        |=> !unlocked_o);

    // R2: the gate only opens right after a key write.
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> $past(key_a_wr_i || key_b_wr_i));

endmodule

// File: rtl/keylock_scratch.sv
// Bank of general-purpose scratch words, writable only while the gate is
// open. Assumes idx_i is in range whenever wr_hit_i is high.
module keylock_scratch #(
    parameter int  DATA_W      = 32,
    parameter int  NUM_SCRATCH = 3,
    localparam int IDX_W       = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_hit_i,
    input  logic                                unlocked_i,
    input  logic [IDX_W-1:0]                    idx_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [NUM_SCRATCH-1:0][DATA_W-1:0]  data_o
);

    logic wr_ok;
    assign wr_ok = wr_hit_i & unlocked_i;

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_word
        // Purpose: hold one scratch word, loaded on a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[g] <= '0;
            end else if (wr_ok && idx_i == IDX_W'(g)) begin
                data_o[g] <= wdata_i;
            end
        end

        // R5: a permitted write lands in the addressed word.
        p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit_i && unlocked_i && idx_i == IDX_W'(g))
            |=> data_o[g] == $past(wdata_i));
    end

    // R4: a locked write leaves the whole bank untouched.
    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !unlocked_i) |=> $stable(data_o));

endmodule

// File: rtl/keylock_regfile.sv
// Top of the two-key write lock: decodes the bus, keeps the key state and
// the scratch bank, returns registered read data and forwards gated write
// enables for non-local addresses to the protected peripheral.
// Assumes single-cycle strobes; the peripheral supplies its own read data.
module keylock_regfile
    import keylock_pkg::*;
#(
    parameter int  ADDR_W      = 8,
    parameter int  DATA_W      = 32,
    parameter int  NUM_SCRATCH = 3,
    localparam int IDX_W       = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              periph_we,
    output logic              unlocked
);

    hit_e                               hit;
    logic [IDX_W-1:0]                   idx;
    logic [NUM_SCRATCH-1:0][DATA_W-1:0] scratch;
    logic [DATA_W-1:0]                  rd_sel;

    keylock_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_SCRATCH (NUM_SCRATCH)
    ) u_decode (
        .addr_i (bus_addr),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    keylock_keys #(
        .DATA_W (DATA_W)
    ) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_a_wr_i (bus_wr && hit == HIT_KEY_A),
        .key_b_wr_i (bus_wr && hit == HIT_KEY_B),
        .wdata_i    (bus_wdata),
        .unlocked_o (unlocked)
    );

    keylock_scratch #(
        .DATA_W      (DATA_W),
        .NUM_SCRATCH (NUM_SCRATCH)
    ) u_scratch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit_i   (bus_wr && hit == HIT_SCRATCH),
        .unlocked_i (unlocked),
        .idx_i      (idx),
        .wdata_i    (bus_wdata),
        .data_o     (scratch)
    );

    // Purpose: gate peripheral writes on the lock state.
    assign periph_we = bus_wr && unlocked && (hit == HIT_NONE);

    // Purpose: select read data; keys and non-local addresses read zero.
    always_comb begin
        rd_sel = '0;
        if (hit == HIT_SCRATCH) begin
            for (int i = 0; i < NUM_SCRATCH; i++) begin
                if (idx == IDX_W'(i)) begin
                    rd_sel = scratch[i];
                end
            end
        end
    end

    // Purpose: register the read result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_sel : '0;
        end
    end

    // R9: every read strobe yields a valid in the next cycle.
    p_rvalid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R6: key registers never reveal their contents.
    p_key_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (hit == HIT_KEY_A || hit == HIT_KEY_B)) |=> bus_rdata == '0);

    // R7: the peripheral enable never rises while the gate is locked.
    p_no_locked_periph_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !periph_we);

endmodule

// File: tb/keylock_regfile_bench.sv
// Scoreboard bench: driver tasks queue expected read words, a monitor pops
// and compares them when bus_rvalid appears.
module keylock_regfile_bench;

    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        periph_we;
    logic        unlocked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    bit          m_a_ok = 1'b0;
    bit          m_b_ok = 1'b0;
    logic [31:0] m_scr [3];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    keylock_regfile u_keylock_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .periph_we  (periph_we),
        .unlocked   (unlocked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_scratch(input logic [7:0] a);
        return a == 8'h60 || a == 8'h64 || a == 8'h68;
    endfunction

    // Start of each operation: lock state reflects all earlier writes.
    task automatic lock_check(input string req);
        check(req, {31'd0, unlocked}, {31'd0, m_a_ok & m_b_ok});
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        bit local_hit;
        @(negedge clk);
        lock_check(req);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        local_hit = is_scratch(a) || a == 8'h6C || a == 8'h70;
        #1;
        check(req, {31'd0, periph_we}, {31'd0, (m_a_ok & m_b_ok) & !local_hit});
        if (a == 8'h6C) m_a_ok = (d == KA);
        else if (a == 8'h70) m_b_ok = (d == KB);
        else if (is_scratch(a) && m_a_ok && m_b_ok) m_scr[(a - 8'h60) >> 2] = d;
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        @(negedge clk);
        lock_check(req);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(is_scratch(a) ? m_scr[(a - 8'h60) >> 2] : 32'd0);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // Monitor: compare each valid read against the scoreboard.
    always @(posedge clk) begin
        #2;
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: actual=valid expected=no read outstanding");
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m_scr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, unlocked}, 32'd0);
        check("R9", {31'd0, bus_rvalid}, 32'd0);
        rd("R1", 8'h60); rd("R1", 8'h64); rd("R1", 8'h68);
        // locked writes
        wr("R4", 8'h60, 32'hDEAD_BEEF);
        wr("R7", 8'h10, 32'h1111_1111);
        rd("R4", 8'h60);
        // partial and wrong keys
        wr("R2", 8'h6C, KA);
        wr("R2", 8'h70, KB ^ 32'h1);
        wr("R2", 8'h64, 32'h5555_5555);
        rd("R2", 8'h64);
        wr("R2", 8'h70, KB);
        rd("R6", 8'h6C); rd("R6", 8'h70);
        // open: scratch writes and readback
        wr("R5", 8'h60, 32'hA5A5_0001);
        rd("R5", 8'h60);
        wr("R5", 8'h64, 32'h0BAD_F00D);
        wr("R5", 8'h68, 32'hFFFF_FFFF);
        rd("R5", 8'h64); rd("R5", 8'h68);
        wr("R7", 8'h10, 32'h2222_2222);
        wr("R7", 8'h64, 32'h1234_5678);
        wr("R8", 8'h74, 32'h7777_7777);
        wr("R8", 8'h61, 32'h6666_6666);
        rd("R8", 8'h60); rd("R8", 8'h64); rd("R8", 8'h68);
        rd("R9", 8'h74); rd("R9", 8'h10);
        // zero on key A locks
        wr("R3", 8'h6C, 32'd0);
        wr("R3", 8'h68, 32'hCAFE_0000);
        wr("R3", 8'h20, 32'h3333_3333);
        rd("R3", 8'h68);
        // reverse order unlock
        wr("R2", 8'h70, KB);
        wr("R2", 8'h6C, KA);
        wr("R5", 8'h68, 32'h0000_0042);
        rd("R5", 8'h68);
        // zero on key B locks, key A still correct
        wr("R3", 8'h70, 32'd0);
        wr("R4", 8'h60, 32'h9999_9999);
        rd("R4", 8'h60);
        idle();
        lock_check("R3");
        idle();
        idle();
        check("R9", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule